// File: doc/BRIEF.md
# Accelerated Soft-Output Update Unit

This unit sits after the check-node processor of a layered min-sum LDPC decoder. It handles one graph edge per cycle. The inputs for an edge are three values:

- the variable-to-check value,
- the freshly computed check-to-variable message,
- the soft output that the variable held before this update.

The unit forms an interim sum and then extrapolates it. It adds 1/32 of the interim value and subtracts 1/32 of the earlier soft output. This pushes the estimate in the direction it is already moving, which speeds up convergence. Both 1/32 products are made with arithmetic shifts, so no multiplier is needed.

Two control inputs change the behaviour for an edge. A bypass control turns the extrapolation off, so the unit performs the plain layered update. A load control preloads the soft output from the channel LLR when decoding starts.

Each result is saturated to a symmetric signed range. A hard-decision bit comes out with the result. The unit has a fixed pipeline of two cycles, and the earlier soft output travels down the pipeline next to its own edge. Soft-output storage, rotation, syndrome checking and iteration control are handled elsewhere.

Top module: `soft_out_accel`

## Requirements
- R1: With `bypass`=1 and `init_mode`=0, the result equals the saturated value of `v2c` + `c2v` (the interim value I).
- R2: With `bypass`=0 and `init_mode`=0, the result equals the saturated value of I + (I >>> 5) − (`so_prev` >>> 5). Both shifts are arithmetic, so they round toward minus infinity.
- R3: With `init_mode`=1, the result equals the saturated `chan_llr`. In that case `v2c`, `c2v` and `so_prev` have no effect.
- R4: Every result is saturated to [−127, +127]. The code −128 never appears on `so_new`.
- R5: `hard_bit` is 0 when the result is zero or positive, and 1 when it is negative.
- R6: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high. No output appears without a matching input.
- R7: Edges may arrive on consecutive cycles with no bubbles. Each result uses the `so_prev` value that came with its own edge.
- R8: During reset, `out_valid`, `so_new` and `hard_bit` are all 0.
- R9: When `init_mode` and `bypass` are both 1, `init_mode` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An edge is presented this cycle |
| init_mode | input | 1 | Load the soft output from the channel LLR |
| bypass | input | 1 | Disable extrapolation (weight of zero) |
| v2c | input | 8 | Signed variable-to-check value |
| c2v | input | 6 | Signed new check-to-variable message |
| so_prev | input | 8 | Signed soft output before this update |
| chan_llr | input | 8 | Signed channel LLR |
| out_valid | output | 1 | `so_new` and `hard_bit` are valid |
| so_new | output | 8 | Signed updated soft output |
| hard_bit | output | 1 | Hard decision: 1 when negative |

## Verification
Two mode controls can be active in the same cycle: the load control and the bypass control. The bench asserts both on one edge and expects the channel value to come out (R9). It does the same with contradictory `v2c`/`c2v` values present, to show they are ignored.

Saturation can coincide with extrapolation on a single edge. Edges are therefore driven whose interim sum is already beyond full scale and whose shift term pushes further. The bench then expects the clamped value.

A burst of back-to-back edges mixes all three modes and changes `so_prev` on every cycle. The scoreboard checks each result value and its arrival cycle against its own edge.

// File: rtl/soft_out_pkg.sv
package soft_out_pkg;

   // Per-edge operating mode carried down the pipeline
   typedef enum logic [1:0] {
      SO_MODE_ACCEL = 2'd0,
      SO_MODE_PLAIN = 2'd1,
      SO_MODE_LOAD  = 2'd2
   } so_mode_e;

endpackage

// File: rtl/sou_front.sv
module sou_front
   import soft_out_pkg::*;
#(
   parameter int SO_W     = 8,
   parameter int V2C_W    = 8,
   parameter int C2V_W    = 6,
   parameter int SHIFT    = 5,
   parameter bit ACCEL_EN = 1'b1,
   parameter int IW       = 9,
   parameter int PW       = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    init_mode,
   input  logic                    bypass,
   input  logic signed [V2C_W-1:0] v2c,
   input  logic signed [C2V_W-1:0] c2v,
   input  logic signed [SO_W-1:0]  so_prev,
   input  logic signed [SO_W-1:0]  chan_llr,
   output logic                    s1_valid,
   output so_mode_e                s1_mode,
   output logic signed [IW-1:0]    s1_val,
   output logic signed [PW-1:0]    s1_prev
);

   logic signed [IW-1:0] sum_c;
   logic signed [IW-1:0] chan_c;
   so_mode_e             mode_c;

   always_comb begin
      sum_c  = IW'(v2c) + IW'(c2v);
      chan_c = IW'(chan_llr);
      if (init_mode)
         mode_c = SO_MODE_LOAD;
      else if (bypass || !ACCEL_EN)
         mode_c = SO_MODE_PLAIN;
      else
         mode_c = SO_MODE_ACCEL;
   end

   // Interim sum and channel value share one register: only one is live per edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_mode  <= SO_MODE_ACCEL;
         s1_val   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_mode <= mode_c;
            s1_val  <= init_mode ? chan_c : sum_c;
         end
      end
   end

   generate
      if (ACCEL_EN) begin : g_prev_delay
         // Upper bits of the prior soft output are its arithmetic shift by SHIFT
         always_ff @(posedge clk) begin
            if (!rst_n)
               s1_prev <= '0;
            else if (in_valid)
               s1_prev <= so_prev[SO_W-1:SHIFT];
         end
      end else begin : g_no_prev
         assign s1_prev = '0;
      end
   endgenerate

endmodule

// File: rtl/sou_back.sv
module sou_back
   import soft_out_pkg::*;
#(
   parameter int SO_W  = 8,
   parameter int SHIFT = 5,
   parameter int IW    = 9,
   parameter int PW    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   s1_valid,
   input  so_mode_e               s1_mode,
   input  logic signed [IW-1:0]   s1_val,
   input  logic signed [PW-1:0]   s1_prev,
   output logic                   out_valid,
   output logic signed [SO_W-1:0] so_new,
   output logic                   hard_bit
);

   localparam int EW      = IW + 2;
   localparam int SAT_MAX = (1 << (SO_W - 1)) - 1;
   localparam logic signed [EW-1:0]   HI_W = EW'(SAT_MAX);
   localparam logic signed [EW-1:0]   LO_W = -HI_W;
   localparam logic signed [SO_W-1:0] HI_O = SO_W'(SAT_MAX);
   localparam logic signed [SO_W-1:0] LO_O = -HI_O;

   function automatic logic signed [SO_W-1:0] clamp(input logic signed [EW-1:0] x);
      if (x > HI_W)
         return HI_O;
      else if (x < LO_W)
         return LO_O;
      else
         return x[SO_W-1:0];
   endfunction

   logic signed [EW-1:0]   ival;
   logic signed [EW-1:0]   pval;
   logic signed [EW-1:0]   acc;
   logic signed [SO_W-1:0] res;

   always_comb begin
      ival = EW'(s1_val);
      pval = EW'(s1_prev);
      if (s1_mode == SO_MODE_ACCEL)
         acc = ival + (ival >>> SHIFT) - pval;
      else
         acc = ival;
      res = clamp(acc);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         so_new    <= '0;
         hard_bit  <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) begin
            so_new   <= res;
            hard_bit <= (res < 0);
         end
      end
   end

endmodule

// File: rtl/soft_out_accel.sv
module soft_out_accel
   import soft_out_pkg::*;
#(
   parameter int SO_W     = 8,
   parameter int V2C_W    = 8,
   parameter int C2V_W    = 6,
   parameter int SHIFT    = 5,
   parameter bit ACCEL_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    init_mode,
   input  logic                    bypass,
   input  logic signed [V2C_W-1:0] v2c,
   input  logic signed [C2V_W-1:0] c2v,
   input  logic signed [SO_W-1:0]  so_prev,
   input  logic signed [SO_W-1:0]  chan_llr,
   output logic                    out_valid,
   output logic signed [SO_W-1:0]  so_new,
   output logic                    hard_bit
);

   localparam int IW = ((V2C_W > C2V_W) ? V2C_W : C2V_W) + 1;
   localparam int PW = SO_W - SHIFT;

   generate
      if (SHIFT < 1 || SHIFT >= SO_W) begin : g_bad_shift
         $error("soft_out_accel: SHIFT must lie in 1..SO_W-1");
      end
      if (IW < SO_W) begin : g_bad_width
         $error("soft_out_accel: interim width must cover SO_W");
      end
   endgenerate

   logic                 s1_valid;
   so_mode_e             s1_mode;
   logic signed [IW-1:0] s1_val;
   logic signed [PW-1:0] s1_prev;

   sou_front #(
      .SO_W(SO_W), .V2C_W(V2C_W), .C2V_W(C2V_W), .SHIFT(SHIFT),
      .ACCEL_EN(ACCEL_EN), .IW(IW), .PW(PW)
   ) front_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .init_mode(init_mode),
      .bypass(bypass), .v2c(v2c), .c2v(c2v), .so_prev(so_prev),
      .chan_llr(chan_llr), .s1_valid(s1_valid), .s1_mode(s1_mode),
      .s1_val(s1_val), .s1_prev(s1_prev)
   );

   sou_back #(
      .SO_W(SO_W), .SHIFT(SHIFT), .IW(IW), .PW(PW)
   ) back_i (
      .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_mode(s1_mode),
      .s1_val(s1_val), .s1_prev(s1_prev), .out_valid(out_valid),
      .so_new(so_new), .hard_bit(hard_bit)
   );

endmodule

// File: rtl/soft_out_accel_chk.sv
module soft_out_accel_chk #(
   parameter int SO_W  = 8,
   parameter int V2C_W = 8,
   parameter int C2V_W = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    init_mode,
   input logic                    bypass,
   input logic signed [V2C_W-1:0] v2c,
   input logic signed [C2V_W-1:0] c2v,
   input logic signed [SO_W-1:0]  so_prev,
   input logic signed [SO_W-1:0]  chan_llr,
   input logic                    out_valid,
   input logic signed [SO_W-1:0]  so_new,
   input logic                    hard_bit
);

   localparam int SAT_MAX = (1 << (SO_W - 1)) - 1;

   function automatic int clampi(input int x);
      if (x > SAT_MAX)  return SAT_MAX;
      if (x < -SAT_MAX) return -SAT_MAX;
      return x;
   endfunction

   // Cycles since reset release, capped at two
   logic [1:0] age;
   always_ff @(posedge clk) begin
      if (!rst_n)
         age <= 2'd0;
      else if (age != 2'd2)
         age <= age + 2'd1;
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

   AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && $past(in_valid && init_mode, 2))
      |-> (int'(so_new) == clampi(int'($past(chan_llr, 2))))); // R3

   AST_PLAIN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2 && $past(in_valid && !init_mode && bypass, 2))
      |-> (int'(so_new) == clampi(int'($past(v2c, 2)) + int'($past(c2v, 2))))); // R1

   AST_SYM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(so_new) >= -SAT_MAX)); // R4

   AST_HARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (hard_bit == (so_new < 0))); // R5

   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(!rst_n) |-> (!out_valid && so_new == '0 && !hard_bit)); // R8

endmodule

bind soft_out_accel soft_out_accel_chk #(
   .SO_W(SO_W), .V2C_W(V2C_W), .C2V_W(C2V_W)
) chk_i (.*);

// File: tb/soft_out_accel_tb_top.sv
`timescale 1ns/1ps
module soft_out_accel_tb_top;

   typedef struct {
      int    so;
      bit    hard;
      int    due;
      string tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              init_mode = 1'b0;
   logic              bypass = 1'b0;
   logic signed [7:0] v2c = '0;
   logic signed [5:0] c2v = '0;
   logic signed [7:0] so_prev = '0;
   logic signed [7:0] chan_llr = '0;
   logic              out_valid;
   logic signed [7:0] so_new;
   logic              hard_bit;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   soft_out_accel dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .init_mode(init_mode),
      .bypass(bypass), .v2c(v2c), .c2v(c2v), .so_prev(so_prev),
      .chan_llr(chan_llr), .out_valid(out_valid), .so_new(so_new),
      .hard_bit(hard_bit)
   );

   function automatic int model(bit ini, bit byp, int v, int c, int p, int ch);
      int i;
      int r;
      if (ini) r = ch;
      else begin
         i = v + c;
         r = byp ? i : i + (i >>> 5) - (p >>> 5);
      end
      if (r > 127)  r = 127;
      if (r < -127) r = -127;
      return r;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic send(bit ini, bit byp, int v, int c, int p, int ch, string tag);
      exp_t e;
      @(negedge clk);
      in_valid  = 1'b1;
      init_mode = ini;
      bypass    = byp;
      v2c       = 8'(v);
      c2v       = 6'(c);
      so_prev   = 8'(p);
      chan_llr  = 8'(ch);
      e.so   = model(ini, byp, v, c, p, ch);
      e.hard = (e.so < 0);
      e.due  = cyc + 2;
      e.tag  = tag;
      q.push_back(e);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         v2c = 8'sd99;
         c2v = -6'sd7;
      end
   endtask

   // Monitor: compare each produced result with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R6 unexpected output", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               check(e.due == cyc, {e.tag, " R6 timing"}, cyc, e.due);
               check(int'(so_new) == e.so, e.tag, int'(so_new), e.so);
               check(hard_bit == e.hard, {e.tag, " R5 hard"}, int'(hard_bit), int'(e.hard));
            end
         end else if (q.size() != 0 && q[0].due <= cyc) begin
            check(1'b0, "R6 missing output", 0, 1);
            void'(q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8 reset valid", int'(out_valid), 0);
      check(so_new == '0, "R8 reset value", int'(so_new), 0);
      check(hard_bit == 1'b0, "R8 reset hard", int'(hard_bit), 0);
      rst_n = 1'b1;
      idle(2);
      check(out_valid == 1'b0, "R8 idle after reset", int'(out_valid), 0);

      send(0, 1, 10, 5, 90, 0, "R1 plain sum");
      idle(3);
      send(0, 1, 120, 31, 0, 0, "R4 plain positive clamp");
      send(0, 1, -128, -32, 0, 0, "R4 plain negative clamp");
      idle(2);
      send(0, 0, 60, 20, 40, 0, "R2 accel positive");
      send(0, 0, -70, -10, -100, 0, "R2 accel negative");
      send(0, 0, -20, 20, 0, 0, "R5 zero result");
      send(0, 0, 0, 0, 31, 0, "R2 small prev no effect");
      send(0, 0, 0, 0, 32, 0, "R5 prev pushes to minus one");
      send(0, 0, 127, 31, -128, 0, "R4 accel clamp high");
      send(0, 0, -128, -32, 127, 0, "R4 accel clamp low");
      idle(1);
      send(1, 0, 100, 20, 50, 55, "R3 load positive");
      send(1, 0, -3, 4, 5, -128, "R3 load clamp");
      send(1, 1, -90, -30, 10, 33, "R9 load beats bypass");
      send(1, 1, 90, 30, -10, -1, "R9 load beats bypass negative");
      idle(4);

      for (int k = 0; k < 24; k++) begin
         int v;
         int c;
         int p;
         v = ((k * 37 + 11) % 256) - 128;
         c = ((k * 13 + 5) % 64) - 32;
         p = ((k * 71 + 3) % 256) - 128;
         send(k % 7 == 3, k % 5 == 0, v, c, p, v - 3, "R7 burst");
      end
      idle(1);
      send(0, 0, 50, 10, 100, 0, "R6 isolated after gap");
      idle(6);

      check(q.size() == 0, "R6 outputs drained", q.size(), 0);
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule